// File: doc/BRIEF.md
# Early-Terminating Sequential Booth Multiplier

This block multiplies two 32-bit integers over several clock cycles and can add a third 32-bit operand to the product. A one-cycle start strobe captures the multiplicand, the multiplier, the addend, the accumulate enable and the signedness select. The block then works through the multiplier eight bits per cycle, recoding each byte as four radix-4 Booth digits in {-2,-1,0,+1,+2}. The top bit of the previous byte is carried in as the overlap bit. Each cycle adds one shifted slice product into a 32-bit partial-sum register. When accumulation is enabled, that register starts from the addend instead of zero, so accumulation costs no cycle.

The block stops once the multiplier bits it has not yet consumed can no longer change the low 32 bits of the result. A small multiplier therefore finishes in one cycle and a full-width one takes four. When it finishes, the block raises a done pulse, drops busy, and presents the low result word together with the number of slice cycles used. Both values hold until the next operation completes. There is no divide function.

Top module: `mul_booth_early`

## Requirements
- R1: In unsigned mode (signed_i = 0), result_o equals (mcand_i * mplier_i + (acc_en_i ? addend_i : 0)) mod 2^32.
- R2: In signed mode (signed_i = 1), result_o equals the two's-complement product plus the optional addend, modulo 2^32.
- R3: In signed mode, cycles_o is the smallest k in 1..3 for which multiplier bits [31 : 8k-1] are all equal, and 4 if there is no such k.
- R4: In unsigned mode, cycles_o is the smallest k in 1..3 for which multiplier bits [31 : 8k-1] are all zero, and 4 if there is no such k.
- R5: Take the edge that samples start_i as edge 0. busy_o is high from edge 0 until edge k, where k is the cycles_o value. At edge k, busy_o falls and done_o rises, and done_o stays high for exactly one cycle.
- R6: A start_i pulse while busy_o is high is ignored. The running operation completes with its own operands and count, and no second done pulse follows.
- R7: Enabling accumulation leaves the cycle count of an operation unchanged.
- R8: While reset is active and after it is released, busy_o, done_o, result_o and cycles_o are all zero.
- R9: result_o and cycles_o change only in a cycle in which done_o is high. Between operations they hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation; sampled only while idle |
| mcand_i | input | 32 | Multiplicand |
| mplier_i | input | 32 | Multiplier, consumed one byte per cycle |
| addend_i | input | 32 | Value added to the product when accumulating |
| acc_en_i | input | 1 | 1 = add addend_i to the product |
| signed_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| result_o | output | 32 | Low 32 bits of the result |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cycles_o | output | 3 | Slice cycles used by the last operation (1..4) |

## Verification
Busy is due one edge after start is sampled. Result, cycle count and the done pulse are due k edges later, and done must be low again one edge after that. The bench drives its inputs on falling edges and samples on the following falling edges. It counts falling edges from the start edge until done appears, and compares that count with the k it derives from the multiplier bits. It checks the product against a modulo-2^32 reference built with the bench's own arithmetic. It also checks that done has dropped one cycle later and that the outputs hold steady for several idle cycles.

// File: rtl/mul_booth_pkg.sv
package mul_booth_pkg;

    // One radix-4 Booth digit: magnitude select plus sign.
    typedef struct packed {
        logic neg;
        logic one;
        logic two;
    } booth_dig_t;

    // Recode a bit triplet {b(2i+1), b(2i), b(2i-1)} into a digit.
    function automatic booth_dig_t booth_recode(input logic [2:0] trip);
        booth_dig_t d;
        d = '0;
        unique case (trip)
            3'b001, 3'b010: d.one = 1'b1;
            3'b011:         d.two = 1'b1;
            3'b100:         begin d.two = 1'b1; d.neg = 1'b1; end
            3'b101, 3'b110: begin d.one = 1'b1; d.neg = 1'b1; end
            default:        d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/mul_booth_digit.sv
module mul_booth_digit
    import mul_booth_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [2:0]      trip_i,
    input  logic [XLEN-1:0] mcand_i,
    output logic [XLEN-1:0] pp_o
);
    booth_dig_t        dig;
    logic [XLEN-1:0]   mag;

    always_comb begin
        dig = booth_recode(trip_i);
        if (dig.two) begin
            mag = mcand_i << 1;
        end else if (dig.one) begin
            mag = mcand_i;
        end else begin
            mag = '0;
        end
        pp_o = dig.neg ? (~mag + XLEN'(1)) : mag;
    end
endmodule

// File: rtl/mul_slice_array.sv
module mul_slice_array #(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned SLICE_W = 8
) (
    input  logic [SLICE_W:0]   bits_i,   // bit 0 is the overlap bit
    input  logic [XLEN-1:0]    mcand_i,
    output logic [XLEN-1:0]    slice_pp_o
);
    localparam int unsigned NDIG = SLICE_W / 2;

    logic [XLEN-1:0] dig_pp [NDIG];

    for (genvar j = 0; j < NDIG; j++) begin : g_dig
        mul_booth_digit #(.XLEN(XLEN)) u_dig (
            .trip_i  (bits_i[2*j+2 : 2*j]),
            .mcand_i (mcand_i),
            .pp_o    (dig_pp[j])
        );
    end

    always_comb begin
        slice_pp_o = '0;
        for (int j = 0; j < NDIG; j++) begin
            slice_pp_o = slice_pp_o + (dig_pp[j] << (2 * j));
        end
    end
endmodule

// File: rtl/mul_stop_detect.sv
module mul_stop_detect #(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned SLICE_W = 8
) (
    input  logic [XLEN-1:0]             mplier_i,
    input  logic                        sgn_i,
    output logic [XLEN/SLICE_W-1:0]     stop_o   // bit k-1: may stop after k slices
);
    localparam int unsigned NSLICE = XLEN / SLICE_W;

    for (genvar k = 1; k < NSLICE; k++) begin : g_chk
        logic [XLEN-k*SLICE_W:0] upper;
        assign upper       = mplier_i[XLEN-1 : k*SLICE_W-1];
        assign stop_o[k-1] = sgn_i ? ((&upper) | ~(|upper)) : ~(|upper);
    end
    assign stop_o[NSLICE-1] = 1'b1;
endmodule

// File: rtl/mul_booth_early.sv
module mul_booth_early #(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned SLICE_W = 8,
    parameter int unsigned CNT_W   = $clog2(XLEN / SLICE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [XLEN-1:0]   mcand_i,
    input  logic [XLEN-1:0]   mplier_i,
    input  logic [XLEN-1:0]   addend_i,
    input  logic              acc_en_i,
    input  logic              signed_i,
    output logic [XLEN-1:0]   result_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [CNT_W-1:0]  cycles_o
);
    localparam int unsigned NSLICE = XLEN / SLICE_W;
    localparam int unsigned IDX_W  = (NSLICE > 1) ? $clog2(NSLICE) : 1;

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [IDX_W-1:0]  idx;
        logic              sgn;
        logic [XLEN-1:0]   mcand;
        logic [XLEN-1:0]   mplier;
        logic [XLEN-1:0]   acc;
        logic [XLEN-1:0]   result;
        logic [CNT_W-1:0]  cycles;
    } state_t;

    state_t state_d, state_q;

    logic [SLICE_W:0]     slice_bits;
    logic [XLEN-1:0]      slice_pp;
    logic [XLEN-1:0]      sum;
    logic [NSLICE-1:0]    stop_vec;

    // Current byte of the multiplier with the overlap bit below it.
    assign slice_bits = SLICE_W'(1) == 0 ? '0 :
                        (SLICE_W+1)'({state_q.mplier, 1'b0} >> (int'(state_q.idx) * SLICE_W));

    mul_slice_array #(.XLEN(XLEN), .SLICE_W(SLICE_W)) u_array (
        .bits_i     (slice_bits),
        .mcand_i    (state_q.mcand),
        .slice_pp_o (slice_pp)
    );

    mul_stop_detect #(.XLEN(XLEN), .SLICE_W(SLICE_W)) u_stop (
        .mplier_i (state_q.mplier),
        .sgn_i    (state_q.sgn),
        .stop_o   (stop_vec)
    );

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        sum          = state_q.acc + (slice_pp << (int'(state_q.idx) * SLICE_W));
        if (!state_q.busy) begin
            if (start_i) begin
                state_d.busy   = 1'b1;
                state_d.idx    = '0;
                state_d.sgn    = signed_i;
                state_d.mcand  = mcand_i;
                state_d.mplier = mplier_i;
                state_d.acc    = acc_en_i ? addend_i : '0;
            end
        end else begin
            state_d.acc = sum;
            if (stop_vec[state_q.idx]) begin
                state_d.busy   = 1'b0;
                state_d.done   = 1'b1;
                state_d.result = sum;
                state_d.cycles = CNT_W'(state_q.idx) + CNT_W'(1);
            end else begin
                state_d.idx = state_q.idx + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result_o = state_q.result;
    assign busy_o   = state_q.busy;
    assign done_o   = state_q.done;
    assign cycles_o = state_q.cycles;
endmodule

// File: rtl/mul_booth_early_chk.sv
module mul_booth_early_chk #(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned CNT_W = 3,
    parameter int unsigned MAXC  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [XLEN-1:0]  result_o,
    input logic [CNT_W-1:0] cycles_o
);
    // R5: the completion pulse lasts a single cycle
    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5: completion and activity never overlap
    assert_done_not_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R5: busy ends only with a completion pulse
    assert_busy_end_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R5: an accepted start raises busy on the next edge
    assert_start_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R3 / R4: reported count is within the slice range
    assert_count_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cycles_o >= CNT_W'(1) && cycles_o <= CNT_W'(MAXC)));

    // R9: result and count move only with the completion pulse
    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(result_o) && $stable(cycles_o)));
endmodule

bind mul_booth_early mul_booth_early_chk #(
    .XLEN  (XLEN),
    .CNT_W (CNT_W),
    .MAXC  (XLEN / SLICE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o),
    .cycles_o (cycles_o)
);

// File: tb/tb_mul_booth_early.sv
module tb_mul_booth_early;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] mcand_i = '0, mplier_i = '0, addend_i = '0;
    logic        acc_en_i = 1'b0, signed_i = 1'b0;
    logic [31:0] result_o;
    logic        busy_o, done_o;
    logic [2:0]  cycles_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    mul_booth_early dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .mcand_i(mcand_i), .mplier_i(mplier_i), .addend_i(addend_i),
        .acc_en_i(acc_en_i), .signed_i(signed_i),
        .result_o(result_o), .busy_o(busy_o), .done_o(done_o), .cycles_o(cycles_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected slice count from the multiplier bits (R3 signed, R4 unsigned).
    function automatic int exp_k(input logic [31:0] b, input logic sgn);
        for (int k = 1; k < 4; k++) begin
            logic [31:0] up;
            logic [31:0] ones;
            up   = b >> (8 * k - 1);
            ones = 32'hFFFF_FFFF >> (8 * k - 1);
            if (up == 0 || (sgn && up == ones)) return k;
        end
        return 4;
    endfunction

    task automatic run_op(input string req, input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] c, input logic acc, input logic sgn,
                          output int used);
        logic [31:0] exp_res;
        int n;
        exp_res = a * b + (acc ? c : 32'd0);
        @(negedge clk);
        mcand_i = a; mplier_i = b; addend_i = c; acc_en_i = acc; signed_i = sgn;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk({req, " R5 busy after start"}, {31'd0, busy_o}, 32'd1);
        n = 0;
        while (!done_o && n < 20) begin
            @(negedge clk);
            n++;
        end
        used = n;
        chk({req, " R5 done arrives k edges after start"}, n, exp_k(b, sgn));
        chk({req, sgn ? " R3 count" : " R4 count"}, {29'd0, cycles_o}, exp_k(b, sgn));
        chk({req, sgn ? " R2 result" : " R1 result"}, result_o, exp_res);
        chk({req, " R5 busy low at done"}, {31'd0, busy_o}, 32'd0);
        @(negedge clk);
        chk({req, " R5 done one cycle"}, {31'd0, done_o}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R8 busy in reset", {31'd0, busy_o}, 32'd0);
        chk("R8 done in reset", {31'd0, done_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 result after reset", result_o, 32'd0);
        chk("R8 cycles after reset", {29'd0, cycles_o}, 32'd0);
    endtask

    task automatic t_unsigned();
        int u;
        run_op("R1 small",   32'd1234,      32'd5,          32'd0, 1'b0, 1'b0, u);
        run_op("R4 bit7",    32'd77,        32'h0000_0080,  32'd0, 1'b0, 1'b0, u);
        run_op("R4 mid",     32'h1234_5678, 32'h0001_2345,  32'd0, 1'b0, 1'b0, u);
        run_op("R4 full",    32'hDEAD_BEEF, 32'hFFFF_FFFF,  32'd0, 1'b0, 1'b0, u);
        run_op("R1 zero",    32'hFFFF_FFFF, 32'd0,          32'd0, 1'b0, 1'b0, u);
    endtask

    task automatic t_signed();
        int u;
        run_op("R2 neg one", 32'hDEAD_BEEF, 32'hFFFF_FFFF,  32'd0, 1'b0, 1'b1, u);
        run_op("R2 negneg",  -32'sd7,       -32'sd3,        32'd0, 1'b0, 1'b1, u);
        run_op("R3 two",     32'd1001,      -32'sd200,      32'd0, 1'b0, 1'b1, u);
        run_op("R3 three",   -32'sd99,      32'h0001_2345,  32'd0, 1'b0, 1'b1, u);
        run_op("R3 full",    32'h7FFF_FFFF, 32'h8000_0001,  32'd0, 1'b0, 1'b1, u);
    endtask

    task automatic t_accum();
        int plain;
        int accd;
        run_op("R7 plain", 32'h0BAD_F00D, 32'h0003_0000, 32'd0,         1'b0, 1'b0, plain);
        run_op("R7 accum", 32'h0BAD_F00D, 32'h0003_0000, 32'hCAFE_0001, 1'b1, 1'b0, accd);
        chk("R7 same count with accumulate", accd, plain);
        run_op("R2 accum signed", -32'sd5, -32'sd6, 32'hFFFF_FFF0, 1'b1, 1'b1, accd);
    endtask

    task automatic t_ignore();
        int n;
        int dones;
        @(negedge clk);
        mcand_i = 32'd3; mplier_i = 32'hFFFF_FFFF; addend_i = '0; acc_en_i = 1'b0; signed_i = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        mcand_i = 32'd9; mplier_i = 32'd2; signed_i = 1'b1;   // start held while busy
        @(negedge clk);
        start_i = 1'b0;
        n = 2; dones = 0;
        while (!done_o && n < 20) begin
            @(negedge clk);
            n++;
        end
        chk("R6 result from first operands", result_o, 32'd3 * 32'hFFFF_FFFF);
        chk("R6 count from first operands", {29'd0, cycles_o}, 32'd4);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (done_o || busy_o) dones++;
        end
        chk("R6 no second operation", dones, 0);
    endtask

    task automatic t_hold();
        logic [31:0] r;
        logic [2:0]  c;
        r = result_o;
        c = cycles_o;
        mcand_i = 32'h5555_5555; mplier_i = 32'h1234_5678;
        repeat (5) @(negedge clk);
        chk("R9 result held", result_o, r);
        chk("R9 cycles held", {29'd0, c}, {29'd0, cycles_o});
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_unsigned();
        t_signed();
        t_accum();
        t_ignore();
        t_hold();
        finished = 1'b1;
        summary();
    end
endmodule